// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit sits between instruction decode and the execute or memory stages of a processor pipeline. Each cycle it may accept one decoded request. The request carries an addressing-mode code, two register-file read values, a 16-bit constant field, a full-width absolute address and the current program counter. From these it forms one 32-bit result. Depending on the mode, that result is either an operand value, a data-memory address or a branch target.

Alongside the result the unit reports two flags. One says the result must be sent to data memory. The other says the result is a jump target for the fetch stage. The result and both flags are registered and appear one clock after the request, together with a valid strobe.

Between requests the registered outputs keep their last values. The constant field is always treated as a signed two's-complement number. All sums wrap modulo 2^32.

Top module: `addr_gen_unit`

## Requirements
- R1: While rst_n is low, out_valid, result, mem_access and is_branch are all 0.
- R2: A request presented with in_valid high at a rising edge produces out_valid high and its result and flags after that edge. out_valid is low after any edge at which in_valid was low. Back-to-back requests are accepted every cycle.
- R3: Mode code 0 (immediate): result is konst sign-extended from 16 to 32 bits, with mem_access 0 and is_branch 0.
- R4: Mode code 1 (direct): result is abs_addr, with mem_access 1 and is_branch 0.
- R5: Mode code 2 (register): result is reg_a, with mem_access 0 and is_branch 0.
- R6: Mode code 3 (register indirect): result is reg_a used as a pointer, with mem_access 1 and is_branch 0.
- R7: Mode code 4 (indexed): result is reg_a plus sign-extended konst modulo 2^32, with mem_access 1 and is_branch 0.
- R8: Mode code 5 (based-indexed): result is reg_a plus reg_b plus sign-extended konst modulo 2^32, with mem_access 1 and is_branch 0. A konst of zero gives the plain two-register sum.
- R9: Mode code 6 (PC-relative): result is pc plus sign-extended konst modulo 2^32, with mem_access 0 and is_branch 1.
- R10: Mode code 7 is reserved: result is 0, with mem_access 0 and is_branch 0.
- R11: In a cycle where in_valid is low, result, mem_access and is_branch keep their previous values whatever the other inputs do.
- R12: mem_access and is_branch are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A request is present this cycle |
| mode | input | 3 | Addressing-mode code, 0 to 7 |
| reg_a | input | 32 | First register read value (operand, pointer or base) |
| reg_b | input | 32 | Second register read value (index) |
| pc | input | 32 | Program counter of the instruction |
| abs_addr | input | 32 | Full absolute address from the instruction |
| konst | input | 16 | Signed constant or offset field |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 32 | Operand value or target address |
| mem_access | output | 1 | Result is a data-memory address |
| is_branch | output | 1 | Result is a branch target |

## Verification
The assertions assume that rst_n is released clear of the clock edge. They also assume that mode, konst and the data inputs are at known values whenever in_valid is high. The checks that link outputs to the mode of the previous cycle rely on the mode input sampled at that edge. The stimulus drives every input at the falling edge, well before the next rising edge. It holds in_valid low during reset. When a request is not wanted, it still drives known but unrelated values on the data inputs, so that the hold behaviour is shown against changing inputs rather than against idle ones.

// File: rtl/ag_pkg.sv
package ag_pkg;

  typedef enum logic [2:0] {
    AM_IMM   = 3'd0,
    AM_DIR   = 3'd1,
    AM_REG   = 3'd2,
    AM_RIND  = 3'd3,
    AM_IDX   = 3'd4,
    AM_BIDX  = 3'd5,
    AM_PCREL = 3'd6,
    AM_RSVD  = 3'd7
  } amode_e;

  localparam int unsigned MODE_W = 3;

endpackage

// File: rtl/ag_sext.sv
module ag_sext #(
  parameter int unsigned CW = 16,
  parameter int unsigned AW = 32
) (
  input  logic [CW-1:0] k_in,
  output logic [AW-1:0] k_ext
);

  localparam int unsigned PADW = (AW > CW) ? (AW - CW) : 0;

  generate
    if (AW > CW) begin : g_widen
      assign k_ext = {{PADW{k_in[CW-1]}}, k_in};
    end else begin : g_trunc
      assign k_ext = k_in[AW-1:0];
    end
  endgenerate

endmodule

// File: rtl/ag_opsel.sv
module ag_opsel
  import ag_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     reg_a,
  input  logic [AW-1:0]     reg_b,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     abs_addr,
  input  logic [AW-1:0]     k_ext,
  output logic [AW-1:0]     term_a,
  output logic [AW-1:0]     term_b,
  output logic [AW-1:0]     term_c,
  output logic              mem_req,
  output logic              br_tgt
);

  always_comb begin
    term_a  = '0;
    term_b  = '0;
    term_c  = '0;
    mem_req = 1'b0;
    br_tgt  = 1'b0;
    case (amode_e'(mode))
      AM_IMM: begin
        term_c = k_ext;
      end
      AM_DIR: begin
        term_a  = abs_addr;
        mem_req = 1'b1;
      end
      AM_REG: begin
        term_a = reg_a;
      end
      AM_RIND: begin
        term_a  = reg_a;
        mem_req = 1'b1;
      end
      AM_IDX: begin
        term_a  = reg_a;
        term_c  = k_ext;
        mem_req = 1'b1;
      end
      AM_BIDX: begin
        term_a  = reg_a;
        term_b  = reg_b;
        term_c  = k_ext;
        mem_req = 1'b1;
      end
      AM_PCREL: begin
        term_a = pc;
        term_c = k_ext;
        br_tgt = 1'b1;
      end
      default: begin
        term_a = '0;
      end
    endcase
  end

endmodule

// File: rtl/ag_sum3.sv
module ag_sum3 #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  input  logic [AW-1:0] c,
  output logic [AW-1:0] s
);

  always_comb begin
    s = a + b + c;
  end

endmodule

// File: rtl/ag_oreg.sv
module ag_oreg #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] d_val,
  input  logic          d_mem,
  input  logic          d_br,
  output logic          q_valid,
  output logic [AW-1:0] q_val,
  output logic          q_mem,
  output logic          q_br
);

  logic [AW-1:0] val_nxt;
  logic          mem_nxt;
  logic          br_nxt;

  always_comb begin
    val_nxt = q_val;
    mem_nxt = q_mem;
    br_nxt  = q_br;
    if (en) begin
      val_nxt = d_val;
      mem_nxt = d_mem;
      br_nxt  = d_br;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_val   <= '0;
      q_mem   <= 1'b0;
      q_br    <= 1'b0;
    end else begin
      q_valid <= en;
      q_val   <= val_nxt;
      q_mem   <= mem_nxt;
      q_br    <= br_nxt;
    end
  end

  p_valid_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> q_valid);

  p_valid_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !q_valid);

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (q_val == $past(d_val)) && (q_mem == $past(d_mem)) && (q_br == $past(d_br)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q_val) && $stable(q_mem) && $stable(q_br));

  p_flags_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_mem && q_br));

endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import ag_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     reg_a,
  input  logic [AW-1:0]     reg_b,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     abs_addr,
  input  logic [CW-1:0]     konst,
  output logic              out_valid,
  output logic [AW-1:0]     result,
  output logic              mem_access,
  output logic              is_branch
);

  logic [AW-1:0] k_ext;
  logic [AW-1:0] t_a;
  logic [AW-1:0] t_b;
  logic [AW-1:0] t_c;
  logic [AW-1:0] sum;
  logic          mem_req;
  logic          br_tgt;

  ag_sext #(.CW(CW), .AW(AW)) u_sext (
    .k_in  (konst),
    .k_ext (k_ext)
  );

  ag_opsel #(.AW(AW)) u_opsel (
    .mode     (mode),
    .reg_a    (reg_a),
    .reg_b    (reg_b),
    .pc       (pc),
    .abs_addr (abs_addr),
    .k_ext    (k_ext),
    .term_a   (t_a),
    .term_b   (t_b),
    .term_c   (t_c),
    .mem_req  (mem_req),
    .br_tgt   (br_tgt)
  );

  ag_sum3 #(.AW(AW)) u_sum (
    .a (t_a),
    .b (t_b),
    .c (t_c),
    .s (sum)
  );

  ag_oreg #(.AW(AW)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (in_valid),
    .d_val   (sum),
    .d_mem   (mem_req),
    .d_br    (br_tgt),
    .q_valid (out_valid),
    .q_val   (result),
    .q_mem   (mem_access),
    .q_br    (is_branch)
  );

  p_branch_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && is_branch) |-> ($past(mode) == 3'd6));

  p_mem_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mem_access) |->
      ($past(mode) == 3'd1 || $past(mode) == 3'd3 ||
       $past(mode) == 3'd4 || $past(mode) == 3'd5));

  p_reg_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd2) |=> (result == $past(reg_a)) && !mem_access);

  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd7) |=> (result == '0) && !mem_access && !is_branch);

endmodule

// File: tb/sim_addr_gen_unit.sv
`timescale 1ns/1ps
module sim_addr_gen_unit;

  typedef struct packed {
    logic [2:0]  md;
    logic [31:0] ra;
    logic [31:0] rb;
    logic [31:0] pcv;
    logic [31:0] ab;
    logic [15:0] k;
    logic [31:0] exp_res;
    logic        exp_mem;
    logic        exp_br;
  } vec_t;

  localparam int NV = 14;
  localparam logic [31:0] J1 = 32'h1111_1111;
  localparam logic [31:0] J2 = 32'h2222_2222;
  localparam logic [31:0] J3 = 32'h3333_3333;
  localparam logic [31:0] J4 = 32'h4444_4444;
  localparam logic [15:0] JK = 16'h5555;

  localparam vec_t VT [NV] = '{
    '{3'd0, J1, J2, J3, J4, 16'h7FFF, 32'h0000_7FFF, 1'b0, 1'b0},
    '{3'd0, J1, J2, J3, J4, 16'h8000, 32'hFFFF_8000, 1'b0, 1'b0},
    '{3'd1, J1, J2, J3, 32'h1234_5678, JK, 32'h1234_5678, 1'b1, 1'b0},
    '{3'd2, 32'hDEAD_BEEF, J2, J3, J4, JK, 32'hDEAD_BEEF, 1'b0, 1'b0},
    '{3'd3, 32'h0000_1000, J2, J3, J4, JK, 32'h0000_1000, 1'b1, 1'b0},
    '{3'd4, 32'h0000_1000, J2, J3, J4, 16'h0010, 32'h0000_1010, 1'b1, 1'b0},
    '{3'd4, 32'h0000_1000, J2, J3, J4, 16'hFFF0, 32'h0000_0FF0, 1'b1, 1'b0},
    '{3'd4, 32'hFFFF_FFF8, J2, J3, J4, 16'h0010, 32'h0000_0008, 1'b1, 1'b0},
    '{3'd5, 32'h0000_2000, 32'h0000_0300, J3, J4, 16'h0004, 32'h0000_2304, 1'b1, 1'b0},
    '{3'd5, 32'h0000_2000, 32'h0000_0300, J3, J4, 16'h0000, 32'h0000_2300, 1'b1, 1'b0},
    '{3'd5, 32'hFFFF_FFFF, 32'h0000_0001, J3, J4, 16'hFFFF, 32'hFFFF_FFFF, 1'b1, 1'b0},
    '{3'd6, J1, J2, 32'h0000_4000, J4, 16'h0020, 32'h0000_4020, 1'b0, 1'b1},
    '{3'd6, J1, J2, 32'h0000_4000, J4, 16'hFFE0, 32'h0000_3FE0, 1'b0, 1'b1},
    '{3'd7, 32'h0000_5555, J2, J3, J4, JK, 32'h0000_0000, 1'b0, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  mode;
  logic [31:0] reg_a;
  logic [31:0] reg_b;
  logic [31:0] pc;
  logic [31:0] abs_addr;
  logic [15:0] konst;
  logic        out_valid;
  logic [31:0] result;
  logic        mem_access;
  logic        is_branch;

  int total;
  int bad;

  addr_gen_unit u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mode       (mode),
    .reg_a      (reg_a),
    .reg_b      (reg_b),
    .pc         (pc),
    .abs_addr   (abs_addr),
    .konst      (konst),
    .out_valid  (out_valid),
    .result     (result),
    .mem_access (mem_access),
    .is_branch  (is_branch)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    in_valid = vld;
    mode     = v.md;
    reg_a    = v.ra;
    reg_b    = v.rb;
    pc       = v.pcv;
    abs_addr = v.ab;
    konst    = v.k;
  endtask

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #500_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t idle;
    total = 0;
    bad   = 0;
    idle  = '{3'd2, J1, J2, J3, J4, JK, 32'h0, 1'b0, 1'b0};
    rst_n = 1'b0;
    drive(idle, 1'b0);
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    chk("R1 out_valid", {31'b0, out_valid}, 32'h0);
    chk("R1 result", result, 32'h0);
    chk("R1 flags", {30'b0, mem_access, is_branch}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 idle out_valid", {31'b0, out_valid}, 32'h0);

    // table walk, back-to-back requests
    for (int i = 0; i < NV; i++) begin
      drive(VT[i], 1'b1);
      @(negedge clk);
      chk("R2 out_valid", {31'b0, out_valid}, 32'h1);
      chk(req_of(VT[i].md), result, VT[i].exp_res);
      chk(req_of(VT[i].md), {31'b0, mem_access}, {31'b0, VT[i].exp_mem});
      chk(req_of(VT[i].md), {31'b0, is_branch}, {31'b0, VT[i].exp_br});
      chk("R12 exclusive", {31'b0, mem_access & is_branch}, 32'h0);
    end

    // R11: hold with in_valid low while inputs change
    drive(VT[8], 1'b1);
    @(negedge clk);
    drive(VT[12], 1'b0);
    @(negedge clk);
    chk("R2 drop out_valid", {31'b0, out_valid}, 32'h0);
    chk("R11 hold result", result, 32'h0000_2304);
    chk("R11 hold mem", {31'b0, mem_access}, 32'h1);
    drive(VT[0], 1'b0);
    @(negedge clk);
    chk("R11 hold result 2", result, 32'h0000_2304);
    chk("R11 hold branch", {31'b0, is_branch}, 32'h0);

    // R9 after idle gap, then mid-run reset
    drive(VT[11], 1'b1);
    @(negedge clk);
    chk("R9 after gap", result, 32'h0000_4020);
    chk("R9 branch flag", {31'b0, is_branch}, 32'h1);
    drive(idle, 1'b0);
    #1;
    rst_n = 1'b0;
    #1;
    chk("R1 async result", result, 32'h0);
    chk("R1 async flags", {30'b0, mem_access, is_branch}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {31'b0, out_valid}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule